// File: doc/BRIEF.md
# Byte-Bus DAC Register Front End

This block is the digital side of a 12-bit voltage-output converter that hangs off an 8-bit microcontroller bus. The bus carries a data byte, a two-bit register select, and active-low chip select and write strobes. Every bus pin is brought into the system clock domain through a synchronizer chain. A write is taken when the synchronized write strobe rises while the chip select, sampled just before that rise, is low. The byte goes to one of three places: a low-byte holding register, a high-nibble holding register or a three-bit mode register.

The 12-bit code presented to the converter core is a registered copy of the two holding registers. It is refreshed on every clock while it is open and frozen otherwise. It opens when the active-low load pin is low or when the software load bit is set. Two hardware pins combine with the software mode bits to give the effective power-down and fast-settling flags. A hardware pin can force either flag on but never force it off. Power-down leaves every stored value untouched, so the old code is still present when power returns.

Top module: `dac_bus_front`

## Requirements
- R1: After reset, with the load pin high, the power-down pin high and the speed pin low, the code output is 0 and both mode flags are 0.
- R2: A write takes effect only when the synchronized write strobe rises while chip select is low. A strobe pulse with chip select high changes no register.
- R3: Select 00 loads the data byte into code bits 7..0. Select 01 loads data bits 3..0 into code bits 11..8, and data bits 7..4 are dropped.
- R4: Select 10 is reserved. A write to it changes neither the code nor either mode flag.
- R5: Select 11 loads the mode register from data bit 2 (software load), bit 1 (software power-down) and bit 0 (software fast). Data bits 7..3 have no effect.
- R6: While the load pin is high and the software load bit is 0, the code output keeps its value even when the holding registers are rewritten.
- R7: While the load pin is low, the code output follows the holding registers.
- R8: While the software load bit is 1, the code output follows the holding registers whatever the load pin level.
- R9: The power-down flag is 1 when the power-down pin is low or the software power-down bit is 1, and is 0 only when the pin is high and the bit is 0.
- R10: The fast flag is 1 when the speed pin is high or the software fast bit is 1, and is 0 only when both are 0.
- R11: Entering and leaving power-down, by pin or by bit, leaves the code output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 8 | Bus data byte |
| bus_sel | input | 2 | Register select |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_we_n | input | 1 | Write strobe, active low, taken on its rising edge |
| load_n | input | 1 | Code load pin, active low, level sensitive |
| pdown_n | input | 1 | Hardware power-down, active low |
| speed_pin | input | 1 | Hardware fast-settling request, active high |
| dac_code | output | 12 | Code presented to the converter core |
| pwr_down | output | 1 | Effective power-down flag |
| fast_mode | output | 1 | Effective fast-settling flag |

## Verification
The bench builds the block with its defaults: an 8-bit bus, a 12-bit code and a two-stage synchronizer. With these values the 4-bit high register is narrower than the bus, so the dropped data bits in R3 can be seen at the ports. The two-flop chain sets how long the bench waits after each bus event. Random traffic mixes the load pin, both mode pins, chip select and every select value, so each row of the override rules for the load, power and speed paths is reached many times against a bench model.

// File: rtl/dac_bus_pkg.sv
package dac_bus_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'b00,
    SEL_HI   = 2'b01,
    SEL_RSV  = 2'b10,
    SEL_MODE = 2'b11
  } reg_sel_e;

  // bit 2: software load, bit 1: software power-down, bit 0: software fast
  typedef struct packed {
    logic soft_load;
    logic soft_pd;
    logic soft_fast;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/dac_sync_chain.sv
module dac_sync_chain #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg_d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_bus_decode.sv
module dac_bus_decode
  import dac_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] d_s,
  input  logic [1:0]        sel_s,
  input  logic              cs_n_s,
  input  logic              we_n_s,
  output logic [DATA_W-1:0] lo_q,
  output logic [HI_W-1:0]   hi_q,
  output mode_t             mode_q
);
  logic              we_prev, cs_prev;
  logic [DATA_W-1:0] d_prev;
  logic [1:0]        sel_prev;
  logic              wr_fire;
  logic              lo_en, hi_en, mode_en;
  logic [DATA_W-1:0] lo_d;
  logic [HI_W-1:0]   hi_d;
  mode_t             mode_d;

  assign wr_fire = we_n_s & ~we_prev & ~cs_prev;

  always_comb begin
    lo_en   = 1'b0;
    hi_en   = 1'b0;
    mode_en = 1'b0;
    if (wr_fire) begin
      unique case (reg_sel_e'(sel_prev))
        SEL_LO:   lo_en   = 1'b1;
        SEL_HI:   hi_en   = 1'b1;
        SEL_MODE: mode_en = 1'b1;
        default:  ;
      endcase
    end
    lo_d   = d_prev;
    hi_d   = d_prev[HI_W-1:0];
    mode_d = mode_t'(d_prev[MODE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev  <= 1'b1;
      cs_prev  <= 1'b1;
      d_prev   <= '0;
      sel_prev <= '0;
    end else begin
      we_prev  <= we_n_s;
      cs_prev  <= cs_n_s;
      d_prev   <= d_s;
      sel_prev <= sel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= '0;
    end else begin
      if (lo_en)   lo_q   <= lo_d;
      if (hi_en)   hi_q   <= hi_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  // R4
  rsv_sel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && sel_prev == SEL_RSV) |=> ($stable(lo_q) && $stable(hi_q) && $stable(mode_q)));

  // R2
  no_strobe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_n_s && !we_prev && !cs_prev) |=> ($stable(lo_q) && $stable(hi_q) && $stable(mode_q)));

  // R3
  hi_from_low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && sel_prev == SEL_HI) |=> hi_q == $past(d_prev[HI_W-1:0]));
endmodule

// File: rtl/dac_out_stage.sv
module dac_out_stage
  import dac_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 4,
  localparam int CODE_W = DATA_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n_s,
  input  logic              pdown_n_s,
  input  logic              speed_s,
  input  mode_t             mode_q,
  input  logic [DATA_W-1:0] lo_q,
  input  logic [HI_W-1:0]   hi_q,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_down,
  output logic              fast_mode
);
  logic              load_open;
  logic [CODE_W-1:0] code_d;
  logic              pd_d, fast_d;

  always_comb begin
    load_open = ~load_n_s | mode_q.soft_load;
    code_d    = {hi_q, lo_q};
    pd_d      = ~pdown_n_s | mode_q.soft_pd;
    fast_d    = speed_s | mode_q.soft_fast;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code  <= '0;
      pwr_down  <= 1'b0;
      fast_mode <= 1'b0;
    end else begin
      if (load_open) dac_code <= code_d;
      pwr_down  <= pd_d;
      fast_mode <= fast_d;
    end
  end

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n_s && !mode_q.soft_load) |=> $stable(dac_code));

  // R7
  code_follow_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_s |=> dac_code == $past({hi_q, lo_q}));

  // R8
  code_follow_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.soft_load |=> dac_code == $past({hi_q, lo_q}));

  // R9
  pd_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdown_n_s || mode_q.soft_pd) |=> pwr_down);

  // R10
  fast_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed_s && !mode_q.soft_fast) |=> !fast_mode);
endmodule

// File: rtl/dac_bus_front.sv
module dac_bus_front
  import dac_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2,
  localparam int HI_W       = CODE_W - DATA_W,
  localparam int SYNC_W     = DATA_W + 2 + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_d,
  input  logic [1:0]        bus_sel,
  input  logic              bus_cs_n,
  input  logic              bus_we_n,
  input  logic              load_n,
  input  logic              pdown_n,
  input  logic              speed_pin,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_down,
  output logic              fast_mode
);
  // reset pattern: strobes, load and power-down pins idle high, speed low
  localparam logic [SYNC_W-1:0] SYNC_RST = {{(DATA_W+2){1'b0}}, 5'b11110};

  logic [SYNC_W-1:0] raw_bus, syn_bus;
  logic [DATA_W-1:0] d_s;
  logic [1:0]        sel_s;
  logic              cs_n_s, we_n_s, load_n_s, pdown_n_s, speed_s;
  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  mode_t             mode_q;

  assign raw_bus = {bus_d, bus_sel, bus_cs_n, bus_we_n, load_n, pdown_n, speed_pin};
  assign {d_s, sel_s, cs_n_s, we_n_s, load_n_s, pdown_n_s, speed_s} = syn_bus;

  dac_sync_chain #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus));

  dac_bus_decode #(.DATA_W(DATA_W), .HI_W(HI_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .d_s(d_s), .sel_s(sel_s), .cs_n_s(cs_n_s),
    .we_n_s(we_n_s), .lo_q(lo_q), .hi_q(hi_q), .mode_q(mode_q));

  dac_out_stage #(.DATA_W(DATA_W), .HI_W(HI_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load_n_s(load_n_s), .pdown_n_s(pdown_n_s),
    .speed_s(speed_s), .mode_q(mode_q), .lo_q(lo_q), .hi_q(hi_q),
    .dac_code(dac_code), .pwr_down(pwr_down), .fast_mode(fast_mode));

  // R11
  pd_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_down) || $fell(pwr_down)) && load_n_s && !mode_q.soft_load |-> $stable(dac_code));
endmodule

// File: tb/tb_dac_bus_front.sv
module tb_dac_bus_front;
  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_d;
  logic [1:0]  bus_sel;
  logic        bus_cs_n, bus_we_n, load_n, pdown_n, speed_pin;
  logic [11:0] dac_code;
  logic        pwr_down, fast_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_lo = 8'h00;
  logic [3:0]  m_hi = 4'h0;
  logic [2:0]  m_mode = 3'b000;
  logic [11:0] m_code = 12'h000;

  always #(CLK_NS/2) clk = ~clk;

  dac_bus_front dut (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .bus_sel(bus_sel), .bus_cs_n(bus_cs_n),
    .bus_we_n(bus_we_n), .load_n(load_n), .pdown_n(pdown_n), .speed_pin(speed_pin),
    .dac_code(dac_code), .pwr_down(pwr_down), .fast_mode(fast_mode));

  function automatic logic exp_pd(logic pin_n, logic [2:0] md);
    return !pin_n || md[1];
  endfunction

  function automatic logic exp_fast(logic pin, logic [2:0] md);
    return pin || md[0];
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic refresh_model();
    if (!load_n || m_mode[2]) m_code = {m_hi, m_lo};
  endtask

  task automatic check(string tag);
    cyc(8);
    refresh_model();
    n_chk++;
    if (dac_code !== m_code) begin
      n_fail++;
      $display("FAIL %s dac_code got %h exp %h", tag, dac_code, m_code);
    end
    if (pwr_down !== exp_pd(pdown_n, m_mode)) begin
      n_fail++;
      $display("FAIL %s pwr_down got %b exp %b", tag, pwr_down, exp_pd(pdown_n, m_mode));
    end
    if (fast_mode !== exp_fast(speed_pin, m_mode)) begin
      n_fail++;
      $display("FAIL %s fast_mode got %b exp %b", tag, fast_mode, exp_fast(speed_pin, m_mode));
    end
  endtask

  task automatic bus_write(logic [1:0] sel, logic [7:0] data, logic cs_low);
    @(negedge clk);
    bus_sel = sel; bus_d = data; bus_cs_n = !cs_low;
    cyc(3); bus_we_n = 1'b0;
    cyc(3); bus_we_n = 1'b1;
    cyc(3); bus_cs_n = 1'b1;
    if (cs_low) begin
      case (sel)
        2'b00: m_lo = data;
        2'b01: m_hi = data[3:0];
        2'b11: m_mode = data[2:0];
        default: ;
      endcase
    end
    refresh_model();
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2613));
    rst_n = 1'b0; bus_d = '0; bus_sel = '0; bus_cs_n = 1'b1; bus_we_n = 1'b1;
    load_n = 1'b1; pdown_n = 1'b1; speed_pin = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    check("R1 reset state");

    // R6 hold while holding registers change, R3 high data bits dropped
    bus_write(2'b00, 8'hA5, 1'b1);
    bus_write(2'b01, 8'hF3, 1'b1);
    check("R6 held with load pin high");
    load_n = 1'b0;
    check("R7 R3 code opens via load pin");
    bus_write(2'b00, 8'h11, 1'b1);
    check("R7 follows new low byte");
    bus_write(2'b10, 8'hFF, 1'b1);
    check("R4 reserved select ignored");
    bus_write(2'b00, 8'h77, 1'b0);
    check("R2 strobe with chip select high ignored");
    bus_write(2'b01, 8'h0C, 1'b0);
    check("R2 high nibble write without chip select ignored");
    load_n = 1'b1;
    bus_write(2'b11, 8'hF8, 1'b1);
    check("R5 upper data bits of mode write ignored");
    bus_write(2'b00, 8'h22, 1'b1);
    check("R6 held after new low byte");
    bus_write(2'b11, 8'h04, 1'b1);
    check("R8 software load opens code");
    bus_write(2'b11, 8'h02, 1'b1);
    check("R9 software power-down");
    bus_write(2'b00, 8'h99, 1'b1);
    bus_write(2'b11, 8'h00, 1'b1);
    check("R11 code kept across power-down by bit");
    pdown_n = 1'b0;
    check("R9 R11 pin power-down keeps code");
    pdown_n = 1'b1;
    check("R11 code restored after pin release");
    speed_pin = 1'b1;
    check("R10 speed pin forces fast");
    bus_write(2'b11, 8'h01, 1'b1);
    speed_pin = 1'b0;
    check("R10 software fast bit");
    bus_write(2'b11, 8'h00, 1'b1);
    check("R10 slow when both clear");

    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0, 1, 2: bus_write(2'($urandom), 8'($urandom), ($urandom_range(0, 3) != 0));
        3: load_n = 1'($urandom);
        4: pdown_n = ($urandom_range(0, 3) != 0);
        default: speed_pin = 1'($urandom);
      endcase
      check("R2 R3 R4 R5 R6 R7 R8 R9 R10 random traffic");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule